// File: doc/BRIEF.md
# Video Timing Generator with Frame Interrupt

This block produces the scan timing for a parallel RGB panel: horizontal sync, vertical sync, a data-enable strobe and the current pixel column and line. Its pace comes from a pixel-clock enable made by an integer divider of the block clock. Each axis walks the same four regions in a fixed order: visible area, front porch, sync pulse, back porch. Every length and the divider are given as the real count minus one.

A sticky frame interrupt can be raised on entry to a selectable vertical region, normally the start of vertical sync. It needs two enables to be set and is cleared by a write-one acknowledge pulse. A line compare output marks the visible line that matches a programmed threshold. Raising the video enable starts the scan from the top-left pixel. Dropping it, or pulsing the synchronous soft reset, returns the counters to idle.

Top module: `vtg_top`

## Requirements
- R1: While `video_en` is low (including after reset), `de`, `hsync`, `vsync`, `pix_tick` and `line_hit` are 0 and `pix_x`, `pix_y` are 0; after reset `irq_pending` is 0.
- R2: With `video_en` high, `pix_tick` is high one cycle in every `clk_div_m1`+1 cycles, first in the cycle `clk_div_m1` cycles after `video_en` rises.
- R3: A `clk_div_m1` value of 255 is clamped to 254, so the pixel period never exceeds 255 clock cycles.
- R4: A line lasts (h_active_m1+1)+(h_front_m1+1)+(h_sync_m1+1)+(h_back_m1+1) pixel ticks, in the order visible, front porch, sync, back porch; `hsync` is high (active high) for the h_sync_m1+1 sync pixels.
- R5: A frame lasts the sum of the four vertical fields plus four lines, in the same region order; `vsync` is high (active high) for v_sync_m1+1 lines.
- R6: `de` is high exactly when both axes are in their visible region.
- R7: The counters advance only on `pix_tick`. `pix_x` gives the column while the line is visible and is 0 otherwise. `pix_y` gives the line while the frame is visible and is 0 otherwise.
- R8: `irq_pending` is set on entry to the vertical region coded by `irq_evt_sel` (2 = sync start), only when `irq_global_en` and `irq_frame_en` are both 1.
- R9: `irq_pending` stays set until `irq_ack` is pulsed high (write-one-to-clear); a set event in the same cycle as the acknowledge wins.
- R10: `line_hit` is high while the visible line index equals `line_thresh`.
- R11: A one-cycle `soft_rst` returns the scan to the first visible pixel and clears `irq_pending`.
- R12: `irq_evt_sel` codes 0, 1 and 3 select entry to the visible area (frame start), the front porch and the back porch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous return to idle |
| video_en | input | 1 | Starts and runs the scan |
| clk_div_m1 | input | 8 | Pixel divider minus one |
| h_active_m1 | input | 12 | Visible pixels per line minus one |
| h_front_m1 | input | 12 | Horizontal front porch minus one |
| h_sync_m1 | input | 12 | Horizontal sync width minus one |
| h_back_m1 | input | 12 | Horizontal back porch minus one |
| v_active_m1 | input | 11 | Visible lines minus one |
| v_front_m1 | input | 11 | Vertical front porch minus one |
| v_sync_m1 | input | 11 | Vertical sync width minus one |
| v_back_m1 | input | 11 | Vertical back porch minus one |
| line_thresh | input | 11 | Line compare value |
| irq_global_en | input | 1 | Global interrupt enable |
| irq_frame_en | input | 1 | Frame interrupt enable |
| irq_evt_sel | input | 2 | Vertical region whose entry sets the interrupt |
| irq_ack | input | 1 | Write-one pulse clearing the pending bit |
| pix_tick | output | 1 | Pixel clock enable |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| de | output | 1 | Data enable |
| pix_x | output | 12 | Visible column |
| pix_y | output | 11 | Visible line |
| line_hit | output | 1 | Line compare match |
| irq_pending | output | 1 | Frame interrupt status |

## Verification
`pix_tick` is decoded from the divider count, so it is due in the same cycle that count reaches the divider value. The scan outputs decode the counter state that the edge carrying a tick updates, so they change in the cycle after that edge. `irq_pending` is set on that same edge. The bench counts cycles from the clock edge that first sees `video_en` and samples every output mid-cycle, one sample per cycle. For sample k, it derives the expected pixel index as k divided by the pixel period and splits that into column, line and region, so the check tracks each result from the cycle its register updates. Acknowledge and soft-reset pulses are driven for exactly one edge and checked in the sample that follows.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
  // Region order on both axes is behaviour: visible, front, sync, back.
  typedef enum logic [1:0] {
    RG_ACT   = 2'd0,
    RG_FRONT = 2'd1,
    RG_SYNC  = 2'd2,
    RG_BACK  = 2'd3
  } region_e;

  function automatic region_e region_after(input region_e r);
    return region_e'(r + 2'd1);
  endfunction
endpackage

// File: rtl/vtg_tick_div.sv
module vtg_tick_div #(
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            run,
  input  logic [DIVW-1:0] div_m1,
  output logic            tick
);
  localparam logic [DIVW-1:0] DIV_MAX_M1 = DIVW'((1 << DIVW) - 2);

  logic [DIVW-1:0] div_eff;
  logic [DIVW-1:0] dcnt_q, dcnt_d;
  logic            at_end;

  assign div_eff = (div_m1 > DIV_MAX_M1) ? DIV_MAX_M1 : div_m1;
  assign at_end  = (dcnt_q >= div_eff);
  assign tick    = run && !clr && at_end;

  always_comb begin
    dcnt_d = dcnt_q;
    if (clr || !run)  dcnt_d = '0;
    else if (at_end)  dcnt_d = '0;
    else              dcnt_d = dcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dcnt_q <= '0;
    else        dcnt_q <= dcnt_d;
  end

  // R3: the divider count never runs past the clamped limit
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dcnt_q <= DIV_MAX_M1);

  // R2: with a nonzero divider, two ticks are never adjacent
  p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div_eff != '0) |=> (!tick || div_eff == '0 || !$stable(div_m1)));
endmodule

// File: rtl/vtg_axis.sv
module vtg_axis
  import vtg_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          step,
  input  logic [CW-1:0] lim_act,
  input  logic [CW-1:0] lim_front,
  input  logic [CW-1:0] lim_sync,
  input  logic [CW-1:0] lim_back,
  output region_e       region_o,
  output logic [CW-1:0] cnt_o,
  output logic          enter_o,
  output region_e       next_o
);
  region_e       region_q, region_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] cur_lim;
  logic          done;

  always_comb begin
    case (region_q)
      RG_ACT:   cur_lim = lim_act;
      RG_FRONT: cur_lim = lim_front;
      RG_SYNC:  cur_lim = lim_sync;
      default:  cur_lim = lim_back;
    endcase
  end

  assign done    = (cnt_q >= cur_lim);
  assign next_o  = region_after(region_q);
  assign enter_o = step && !clr && done;

  always_comb begin
    region_d = region_q;
    cnt_d    = cnt_q;
    if (clr) begin
      region_d = RG_ACT;
      cnt_d    = '0;
    end else if (step) begin
      if (done) begin
        region_d = next_o;
        cnt_d    = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      region_q <= RG_ACT;
      cnt_q    <= '0;
    end else begin
      region_q <= region_d;
      cnt_q    <= cnt_d;
    end
  end

  assign region_o = region_q;
  assign cnt_o    = cnt_q;

  // R4: regions are visited only in the fixed order
  p_region_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clr) |=> (region_q == $past(region_q) ||
                        region_q == region_after($past(region_q))));

  // R7: nothing moves without a step
  p_hold_no_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !clr) |=> ($stable(cnt_q) && $stable(region_q)));
endmodule

// File: rtl/vtg_frame_irq.sv
module vtg_frame_irq
  import vtg_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    clr,
  input  logic    evt_enter,
  input  region_e evt_region,
  input  logic [1:0] sel,
  input  logic    g_en,
  input  logic    f_en,
  input  logic    ack,
  output logic    pending
);
  logic pend_q, pend_d;
  logic set_evt;

  assign set_evt = evt_enter && (evt_region == region_e'(sel)) && g_en && f_en;

  always_comb begin
    pend_d = pend_q;
    if (clr)          pend_d = 1'b0;
    else if (set_evt) pend_d = 1'b1;
    else if (ack)     pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assign pending = pend_q;

  // R8: status only rises while both enables are on
  p_set_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> $past(g_en && f_en));

  // R9: acknowledge with no competing event clears the status
  p_ack_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !evt_enter) |=> !pend_q);

  // R9: status is sticky without acknowledge or soft reset
  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !ack && !clr) |=> pend_q);
endmodule

// File: rtl/vtg_top.sv
module vtg_top
  import vtg_pkg::*;
#(
  parameter int HW   = 12,
  parameter int VW   = 11,
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            soft_rst,
  input  logic            video_en,
  input  logic [DIVW-1:0] clk_div_m1,
  input  logic [HW-1:0]   h_active_m1,
  input  logic [HW-1:0]   h_front_m1,
  input  logic [HW-1:0]   h_sync_m1,
  input  logic [HW-1:0]   h_back_m1,
  input  logic [VW-1:0]   v_active_m1,
  input  logic [VW-1:0]   v_front_m1,
  input  logic [VW-1:0]   v_sync_m1,
  input  logic [VW-1:0]   v_back_m1,
  input  logic [VW-1:0]   line_thresh,
  input  logic            irq_global_en,
  input  logic            irq_frame_en,
  input  logic [1:0]      irq_evt_sel,
  input  logic            irq_ack,
  output logic            pix_tick,
  output logic            hsync,
  output logic            vsync,
  output logic            de,
  output logic [HW-1:0]   pix_x,
  output logic [VW-1:0]   pix_y,
  output logic            line_hit,
  output logic            irq_pending
);
  // Asynchronous assert, synchronous release.
  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  logic          axis_clr;
  logic          h_step, v_step;
  region_e       h_reg, v_reg, h_next, v_next;
  logic [HW-1:0] h_cnt;
  logic [VW-1:0] v_cnt;
  logic          h_enter, v_enter;
  logic          h_wrap;

  assign axis_clr = soft_rst || !video_en;

  vtg_tick_div #(.DIVW(DIVW)) u_div (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .clr    (soft_rst),
    .run    (video_en),
    .div_m1 (clk_div_m1),
    .tick   (pix_tick)
  );

  assign h_step = pix_tick;
  assign h_wrap = h_enter && (h_next == RG_ACT);
  assign v_step = pix_tick && h_wrap;

  vtg_axis #(.CW(HW)) u_haxis (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .clr       (axis_clr),
    .step      (h_step),
    .lim_act   (h_active_m1),
    .lim_front (h_front_m1),
    .lim_sync  (h_sync_m1),
    .lim_back  (h_back_m1),
    .region_o  (h_reg),
    .cnt_o     (h_cnt),
    .enter_o   (h_enter),
    .next_o    (h_next)
  );

  vtg_axis #(.CW(VW)) u_vaxis (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .clr       (axis_clr),
    .step      (v_step),
    .lim_act   (v_active_m1),
    .lim_front (v_front_m1),
    .lim_sync  (v_sync_m1),
    .lim_back  (v_back_m1),
    .region_o  (v_reg),
    .cnt_o     (v_cnt),
    .enter_o   (v_enter),
    .next_o    (v_next)
  );

  vtg_frame_irq u_irq (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .clr        (soft_rst),
    .evt_enter  (v_enter),
    .evt_region (v_next),
    .sel        (irq_evt_sel),
    .g_en       (irq_global_en),
    .f_en       (irq_frame_en),
    .ack        (irq_ack),
    .pending    (irq_pending)
  );

  logic h_vis, v_vis;
  assign h_vis = video_en && (h_reg == RG_ACT);
  assign v_vis = video_en && (v_reg == RG_ACT);

  assign hsync    = video_en && (h_reg == RG_SYNC);
  assign vsync    = video_en && (v_reg == RG_SYNC);
  assign de       = h_vis && v_vis;
  assign pix_x    = h_vis ? h_cnt : '0;
  assign pix_y    = v_vis ? v_cnt : '0;
  assign line_hit = v_vis && (v_cnt == line_thresh);

  // R6: data enable never overlaps a sync pulse
  p_de_excl_r6: assert property (@(posedge clk) disable iff (!rst_n_int)
    de |-> (!hsync && !vsync));

  // R5: vertical sync starts only on a pixel step
  p_vsync_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_n_int)
    $rose(vsync) |-> $past(pix_tick));

  // R10: a line match reports the compared visible line
  p_line_hit_r10: assert property (@(posedge clk) disable iff (!rst_n_int)
    line_hit |-> (pix_y == line_thresh));
endmodule

// File: tb/vtg_top_bench.sv
module vtg_top_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        soft_rst, video_en;
  logic [7:0]  clk_div_m1;
  logic [11:0] h_active_m1, h_front_m1, h_sync_m1, h_back_m1;
  logic [10:0] v_active_m1, v_front_m1, v_sync_m1, v_back_m1, line_thresh;
  logic        irq_global_en, irq_frame_en, irq_ack;
  logic [1:0]  irq_evt_sel;
  logic        pix_tick, hsync, vsync, de, line_hit, irq_pending;
  logic [11:0] pix_x;
  logic [10:0] pix_y;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  vtg_top u_vtg_top (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .video_en(video_en),
    .clk_div_m1(clk_div_m1),
    .h_active_m1(h_active_m1), .h_front_m1(h_front_m1),
    .h_sync_m1(h_sync_m1), .h_back_m1(h_back_m1),
    .v_active_m1(v_active_m1), .v_front_m1(v_front_m1),
    .v_sync_m1(v_sync_m1), .v_back_m1(v_back_m1),
    .line_thresh(line_thresh),
    .irq_global_en(irq_global_en), .irq_frame_en(irq_frame_en),
    .irq_evt_sel(irq_evt_sel), .irq_ack(irq_ack),
    .pix_tick(pix_tick), .hsync(hsync), .vsync(vsync), .de(de),
    .pix_x(pix_x), .pix_y(pix_y), .line_hit(line_hit),
    .irq_pending(irq_pending)
  );

  // div, ha, hf, hs, hb, va, vf, vs, vb, expected frame length in cycles
  localparam int NV = 4;
  localparam int VT [NV][10] = '{
    '{0, 3, 1, 0, 1, 2, 0, 1, 0, 63},
    '{2, 4, 0, 1, 2, 1, 1, 0, 1, 231},
    '{1, 7, 2, 2, 2, 3, 0, 0, 0, 238},
    '{0, 0, 0, 0, 0, 0, 0, 0, 0, 16}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic smp();
    @(negedge clk);
    #1;
  endtask

  function automatic int region_of(input int pos, input int a, input int f, input int s);
    if (pos <= a) return 0;
    if (pos <= a + f + 1) return 1;
    if (pos <= a + f + s + 2) return 2;
    return 3;
  endfunction

  // Expected outputs for sample k after video_en rises, from R2 R4 R5 R6 R7 R10
  function automatic void model(input int vi, input int k,
      output bit ehs, output bit evs, output bit ede,
      output int ex, output int ey, output bit elh);
    int d, ht, vt, p, x, y, hr, vr;
    d  = VT[vi][0] + 1;
    ht = VT[vi][1] + VT[vi][2] + VT[vi][3] + VT[vi][4] + 4;
    vt = VT[vi][5] + VT[vi][6] + VT[vi][7] + VT[vi][8] + 4;
    p  = k / d;
    x  = p % ht;
    y  = (p / ht) % vt;
    hr = region_of(x, VT[vi][1], VT[vi][2], VT[vi][3]);
    vr = region_of(y, VT[vi][5], VT[vi][6], VT[vi][7]);
    ehs = (hr == 2);
    evs = (vr == 2);
    ede = (hr == 0) && (vr == 0);
    ex  = (hr == 0) ? x : 0;
    ey  = (vr == 0) ? y : 0;
    elh = (vr == 0) && (y == VT[vi][5]);
  endfunction

  task automatic load_cfg(input int vi);
    clk_div_m1  = 8'(VT[vi][0]);
    h_active_m1 = 12'(VT[vi][1]);
    h_front_m1  = 12'(VT[vi][2]);
    h_sync_m1   = 12'(VT[vi][3]);
    h_back_m1   = 12'(VT[vi][4]);
    v_active_m1 = 11'(VT[vi][5]);
    v_front_m1  = 11'(VT[vi][6]);
    v_sync_m1   = 11'(VT[vi][7]);
    v_back_m1   = 11'(VT[vi][8]);
    line_thresh = 11'(VT[vi][5]);
  endtask

  task automatic go_idle();
    video_en = 1'b0;
    irq_global_en = 1'b0;
    irq_frame_en = 1'b0;
    irq_ack = 1'b0;
    soft_rst = 1'b1;
    smp();
    soft_rst = 1'b0;
    smp();
  endtask

  // Start scan and return first sample index with irq_pending high (-1 if none)
  task automatic run_irq(input int vi, input bit ge, input bit fe, input logic [1:0] sel,
                         input int n, output int first);
    load_cfg(vi);
    irq_global_en = ge;
    irq_frame_en  = fe;
    irq_evt_sel   = sel;
    video_en = 1'b1;
    #1;
    first = -1;
    for (int k = 0; k < n; k++) begin
      if (k > 0) smp();
      if (irq_pending && first < 0) first = k;
    end
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", n_chk, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int first;
    int ticks;
    rst_n = 1'b0;
    soft_rst = 1'b0; video_en = 1'b0; irq_ack = 1'b0;
    irq_global_en = 1'b0; irq_frame_en = 1'b0; irq_evt_sel = 2'd2;
    load_cfg(0);
    repeat (3) smp();
    // R1: reset state
    check(!de && !hsync && !vsync && !pix_tick && !line_hit && !irq_pending,
          "R1 outputs in reset", int'({de, hsync, vsync, pix_tick, line_hit, irq_pending}), 0);
    rst_n = 1'b1;
    repeat (4) smp();
    check(!de && !hsync && !vsync && !pix_tick && pix_x == 0 && pix_y == 0 && !irq_pending,
          "R1 idle after reset", int'({de, hsync, vsync, pix_tick, irq_pending}), 0);

    // Vector walk
    for (int vi = 0; vi < NV; vi++) begin
      int bad_h, bad_v, bad_de, bad_pos, bad_lh, nt, firstp, firstv, frm;
      bit ehs, evs, ede, elh;
      int ex, ey;
      bad_h = 0; bad_v = 0; bad_de = 0; bad_pos = 0; bad_lh = 0; nt = 0;
      firstp = -1; firstv = -1;
      frm = VT[vi][9];
      go_idle();
      load_cfg(vi);
      irq_global_en = 1'b1; irq_frame_en = 1'b1; irq_evt_sel = 2'd2;
      video_en = 1'b1;
      #1;
      for (int k = 0; k < frm; k++) begin
        if (k > 0) smp();
        model(vi, k, ehs, evs, ede, ex, ey, elh);
        if (hsync !== ehs) bad_h++;
        if (vsync !== evs) bad_v++;
        if (de !== ede) bad_de++;
        if (int'(pix_x) != ex || int'(pix_y) != ey) bad_pos++;
        if (line_hit !== elh) bad_lh++;
        if (pix_tick) nt++;
        if (evs && firstv < 0) firstv = k;
        if (irq_pending && firstp < 0) firstp = k;
      end
      check(bad_h == 0, $sformatf("R4 hsync pattern vec%0d", vi), bad_h, 0);
      check(bad_v == 0, $sformatf("R5 vsync pattern vec%0d", vi), bad_v, 0);
      check(bad_de == 0, $sformatf("R6 de pattern vec%0d", vi), bad_de, 0);
      check(bad_pos == 0, $sformatf("R7 position vec%0d", vi), bad_pos, 0);
      check(bad_lh == 0, $sformatf("R10 line_hit vec%0d", vi), bad_lh, 0);
      check(nt == frm / (VT[vi][0] + 1), $sformatf("R2 tick count vec%0d", vi),
            nt, frm / (VT[vi][0] + 1));
      check(firstp == firstv && firstv >= 0, $sformatf("R8 irq at vsync vec%0d", vi),
            firstp, firstv);
      video_en = 1'b0;
      #1;
      check(!de && !hsync && !vsync && !pix_tick && !line_hit,
            $sformatf("R1 idle on disable vec%0d", vi),
            int'({de, hsync, vsync, pix_tick, line_hit}), 0);
    end

    // R3: divider value 255 is clamped to a 255-cycle period
    go_idle();
    load_cfg(0);
    clk_div_m1 = 8'd255;
    video_en = 1'b1;
    #1;
    ticks = 0;
    for (int k = 0; k < 510; k++) begin
      if (k > 0) smp();
      if (pix_tick) ticks++;
    end
    check(ticks == 2, "R3 clamped divider ticks", ticks, 2);

    // R8: each enable alone is not enough
    go_idle();
    run_irq(0, 1'b0, 1'b1, 2'd2, 70, first);
    check(first == -1, "R8 global enable off", first, -1);
    go_idle();
    run_irq(0, 1'b1, 1'b0, 2'd2, 70, first);
    check(first == -1, "R8 frame enable off", first, -1);

    // R12: other event selects (0 frame start, 1 front porch, 3 back porch)
    go_idle();
    run_irq(0, 1'b1, 1'b1, 2'd0, 70, first);
    check(first == 63, "R12 select visible start", first, 63);
    go_idle();
    run_irq(0, 1'b1, 1'b1, 2'd1, 70, first);
    check(first == 27, "R12 select front porch", first, 27);
    go_idle();
    run_irq(0, 1'b1, 1'b1, 2'd3, 70, first);
    check(first == 54, "R12 select back porch", first, 54);

    // R9: sticky, write-one clear, set wins over clear
    go_idle();
    run_irq(0, 1'b1, 1'b1, 2'd2, 50, first);
    check(irq_pending == 1'b1, "R9 sticky without ack", int'(irq_pending), 1);
    irq_ack = 1'b1;
    smp();
    irq_ack = 1'b0;
    check(irq_pending == 1'b0, "R9 ack clears", int'(irq_pending), 0);
    // now at sample 50; next vsync entry is at sample 99
    for (int k = 51; k < 99; k++) begin
      if (k == 98) begin
        smp();
        irq_ack = 1'b1;
      end else begin
        smp();
      end
    end
    smp();
    irq_ack = 1'b0;
    check(irq_pending == 1'b1, "R9 set wins over ack", int'(irq_pending), 1);

    // R11: soft reset mid-frame
    go_idle();
    run_irq(1, 1'b1, 1'b1, 2'd2, 141, first);
    check(first == 132, "R8 vec1 irq before soft reset", first, 132);
    soft_rst = 1'b1;
    smp();
    soft_rst = 1'b0;
    check(pix_x == 0 && pix_y == 0 && de && !hsync && !vsync && !irq_pending,
          "R11 soft reset to origin", int'({pix_x, de, irq_pending}), 2);

    go_idle();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule